// File: doc/BRIEF.md
# Bitmap Tile Population Counter

This block shrinks a streamed binary character bitmap into a coarse feature matrix. A 32x32 one-bit-per-pixel image arrives one 32-bit row per accepted beat. The image is split into non-overlapping 4x4 tiles, and for each tile the block reports how many of its sixteen pixels are set. The result is an 8x8 matrix of values from 0 to 16, which a downstream classifier can use as a compact input.

The block does not store the frame. Eight column-group accumulators, one per tile column, gather the counts over four consecutive rows. When the fourth row of a group is accepted, the block emits one output row of eight 5-bit counts together with the index of that tile row. A row flagged as frame start discards any partial group and begins tile row 0. The output uses a valid/ready handshake. While an output row waits for the consumer, new input rows are refused, so no input row can be lost.

Top module: `bitmap_tile_counter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Output cell c sits at `out_counts[5c+4:5c]` and holds the number of 1 bits in input columns `31-4c` down to `28-4c`, summed over the four rows of its group. Bit 31 of `in_row` is the leftmost pixel.
- R3: Every output cell lies in the range 0 to 16.
- R4: `out_valid` rises in the cycle after the fourth accepted row of a group. A 32-row frame yields exactly 8 output rows.
- R5: `out_row` carries the tile-row index, counting 0 to 7 in frame order from the last frame start.
- R6: An accepted row with `in_sof` high becomes row 0 of tile row 0. Rows of an unfinished earlier group do not contribute to any later output.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_counts` and `out_row` hold. A row presented with `in_valid` low has no effect on any output.
- R8: Each group starts from zero counts, so rows of one group never add to the next group's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block |
| in_valid | input | 1 | `in_row` holds a pixel row |
| in_sof | input | 1 | This row is the first row of a frame |
| in_row | input | 32 | One pixel row. Bit 31 is the leftmost pixel |
| in_ready | output | 1 | The block accepts a row in this cycle |
| out_valid | output | 1 | `out_counts` and `out_row` are valid |
| out_ready | input | 1 | The consumer takes the output row |
| out_counts | output | 40 | Eight 5-bit tile counts. Cell 0 is in the lowest bits |
| out_row | output | 3 | Tile-row index of this output |

## Verification
The embedded properties check on every cycle that:
- no accumulator or emitted cell passes its limit;
- a group that starts at a frame start begins from at most one row's worth of pixels;
- the fourth accepted row always raises `out_valid`;
- a stalled output row stays frozen.

The exact tile values, the placement of cells in the output word, the row numbering, and the discarding of a partial group after a restart can only be shown by the directed frames. The bench checks these against its own tile-count model, using all-zero, all-one, checkerboard and random images, idle gaps and back-pressure.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int unsigned BD_ROW_W_DEF = 32;
  localparam int unsigned BD_TILE_DEF  = 4;

  // Width needed to hold a count from 0 up to tile*tile.
  function automatic int unsigned bd_cnt_w(input int unsigned tile);
    return $clog2(tile * tile + 1);
  endfunction
endpackage

// File: rtl/bd_rst_sync.sv
module bd_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/bd_lane_count.sv
module bd_lane_count #(
  parameter int unsigned TILE = 4,
  parameter int unsigned CW   = 5
) (
  input  logic [TILE-1:0] bits,
  output logic [CW-1:0]   ones
);
  always_comb begin
    ones = '0;
    for (int k = 0; k < TILE; k++) ones = ones + CW'(bits[k]);
  end
endmodule

// File: rtl/bd_lane_acc.sv
module bd_lane_acc #(
  parameter int unsigned TILE = 4,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          drop,
  input  logic [CW-1:0] add,
  output logic [CW-1:0] next_o
);
  localparam logic [CW-1:0] CELL_MAX = CW'(TILE * TILE);
  localparam logic [CW-1:0] HOLD_MAX = CW'(TILE * (TILE - 1));
  localparam logic [CW-1:0] ROW_MAX  = CW'(TILE);

  logic [CW-1:0] acc_q;

  assign next_o = (clr ? '0 : acc_q) + add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= drop ? '0 : next_o;
  end

  // R3: a held partial sum never exceeds three rows, and an emitted cell never exceeds 16.
  p_cell_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= HOLD_MAX) && (next_o <= CELL_MAX));

  // R8: a group started from a frame start holds one row's worth at most.
  p_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr && !drop) |=> (acc_q <= ROW_MAX));
endmodule

// File: rtl/bitmap_tile_counter.sv
module bitmap_tile_counter
  import bd_pkg::*;
#(
  parameter  int unsigned ROW_W = BD_ROW_W_DEF,
  parameter  int unsigned TILE  = BD_TILE_DEF,
  localparam int unsigned LANES = ROW_W / TILE,
  localparam int unsigned CW    = bd_cnt_w(TILE),
  localparam int unsigned SW    = $clog2(TILE),
  localparam int unsigned GW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic [ROW_W-1:0]    in_row,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*CW-1:0] out_counts,
  output logic [GW-1:0]       out_row
);
  logic rst_n_s;
  bd_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  logic [SW-1:0]       sub_q, sub_d;
  logic [GW-1:0]       grp_q, grp_d;
  logic                ov_q, ov_d;
  logic [LANES*CW-1:0] cnt_q, cells;
  logic [GW-1:0]       orow_q;
  logic                in_fire, last_fire;

  assign in_ready  = !ov_q || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign last_fire = in_fire && !in_sof && (sub_q == SW'(TILE - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] add, nxt;
    bd_lane_count #(.TILE(TILE), .CW(CW)) u_cnt (
      .bits(in_row[ROW_W-1-g*TILE -: TILE]), .ones(add));
    bd_lane_acc #(.TILE(TILE), .CW(CW)) u_acc (
      .clk(clk), .rst_n(rst_n_s), .en(in_fire), .clr(in_sof),
      .drop(last_fire), .add(add), .next_o(nxt));
    assign cells[g*CW +: CW] = nxt;
  end

  // next state
  always_comb begin
    sub_d = sub_q;
    grp_d = grp_q;
    ov_d  = ov_q;
    if (in_sof) begin
      sub_d = SW'(1);
      grp_d = '0;
    end else if (sub_q == SW'(TILE - 1)) begin
      sub_d = '0;
      grp_d = grp_q + GW'(1);
    end else begin
      sub_d = sub_q + SW'(1);
    end
    if (ov_q && out_ready) ov_d = 1'b0;
    if (last_fire)         ov_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sub_q  <= '0;
      grp_q  <= '0;
      ov_q   <= 1'b0;
      cnt_q  <= '0;
      orow_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (in_fire) begin
        sub_q <= sub_d;
        grp_q <= grp_d;
      end
      if (last_fire) begin
        cnt_q  <= cells;
        orow_q <= grp_q;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_counts = cnt_q;
  assign out_row    = orow_q;

  // R4: the fourth accepted row of a group always produces an output row.
  p_emit_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    last_fire |=> (out_valid && sub_q == '0));

  // R7: a stalled output row is frozen.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_counts) && $stable(out_row)));

  // R6: a frame start restarts at row 1 of tile row 0.
  p_sof_restart_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_fire && in_sof) |=> (grp_q == '0 && sub_q == SW'(1)));
endmodule

// File: tb/bitmap_tile_counter_tb.sv
module bitmap_tile_counter_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_ready, out_valid, out_ready;
  logic [31:0] in_row;
  logic [39:0] out_counts;
  logic [2:0]  out_row;

  int errs = 0, checks = 0, cap_n = 0;
  bit done = 1'b0;
  logic [31:0] frm [32];
  logic [39:0] cap_cnt [16];
  logic [2:0]  cap_row [16];

  always #2.5 clk = ~clk;

  bitmap_tile_counter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_row(in_row), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_counts(out_counts), .out_row(out_row));

  // Record each output handshake. Inputs change just after posedge, so values seen here hold at the next edge.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (cap_n < 16) begin
        cap_cnt[cap_n] = out_counts;
        cap_row[cap_n] = out_row;
      end
      cap_n++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [39:0] exp_row(input int g);
    logic [39:0] v;
    v = '0;
    for (int c = 0; c < 8; c++) begin
      int n = 0;
      for (int rr = 0; rr < 4; rr++)
        for (int k = 0; k < 4; k++) n += int'(frm[4*g+rr][31-4*c-k]);
      v[c*5 +: 5] = 5'(n);
    end
    return v;
  endfunction

  // Called just after a posedge. Returns just after the posedge that accepted the row.
  task automatic send_row(input logic [31:0] d, input logic s);
    in_valid = 1'b1; in_row = d; in_sof = s;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_row = 32'hFFFF_FFFF;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic run_frame(input string name, input int gap);
    cap_n = 0;
    for (int r = 0; r < 32; r++) begin
      send_row(frm[r], r == 0);
      if (gap > 0) idle(gap);
    end
    idle(3);
    chk({name, " R4 rows per frame"}, cap_n, 8);
    for (int g = 0; g < 8; g++) begin
      chk({name, " R5 row index"}, cap_row[g], g);
      chk({name, " R2 R3 tile counts"}, cap_cnt[g], exp_row(g));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_zero();
    for (int r = 0; r < 32; r++) frm[r] = '0;
    run_frame("zero", 0);
  endtask

  task automatic t_ones();
    for (int r = 0; r < 32; r++) frm[r] = 32'hFFFF_FFFF;
    run_frame("ones R3 full tile", 0);
  endtask

  task automatic t_checker();
    for (int r = 0; r < 32; r++) frm[r] = r[0] ? 32'h5555_5555 : 32'hAAAA_AAAA;
    run_frame("checker", 0);
  endtask

  task automatic t_random_gaps();
    for (int r = 0; r < 32; r++) frm[r] = $urandom;
    run_frame("random gaps R7 idle ignored", 2);
  endtask

  task automatic t_timing();
    for (int r = 0; r < 32; r++) frm[r] = $urandom;
    for (int r = 0; r < 3; r++) send_row(frm[r], r == 0);
    @(negedge clk);
    chk("R4 no output before fourth row", out_valid, 0);
    @(posedge clk); #1;
    send_row(frm[3], 1'b0);
    @(negedge clk);
    chk("R4 output after fourth row", out_valid, 1);
    chk("R2 first tile row", out_counts, exp_row(0));
    @(posedge clk); #1;
  endtask

  task automatic t_backpressure();
    for (int r = 0; r < 32; r++) frm[r] = $urandom;
    out_ready = 1'b0;
    for (int r = 0; r < 4; r++) send_row(frm[r], r == 0);
    in_valid = 1'b1; in_row = frm[4];
    repeat (3) begin
      @(negedge clk);
      chk("R7 in_ready low while stalled", in_ready, 0);
      chk("R7 counts held", out_counts, exp_row(0));
      chk("R7 row index held", out_row, 0);
    end
    @(posedge clk); #1;
    cap_n = 0;
    out_ready = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int r = 5; r < 8; r++) send_row(frm[r], 1'b0);
    idle(3);
    chk("R7 outputs after release", cap_n, 2);
    chk("R7 held row delivered", cap_cnt[0], exp_row(0));
    chk("R8 second group fresh", cap_cnt[1], exp_row(1));
    chk("R5 second row index", cap_row[1], 1);
  endtask

  task automatic t_sof_restart();
    for (int r = 0; r < 6; r++) send_row($urandom, r == 0);
    idle(2);
    for (int r = 0; r < 32; r++) frm[r] = $urandom;
    run_frame("R6 restart mid frame", 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_row = '0; out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);
    t_reset();
    t_zero();
    t_ones();
    t_checker();
    t_random_gaps();
    t_timing();
    t_backpressure();
    t_sof_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule